// File: doc/BRIEF.md
# UART Frame Transmitter with Break and Idle Sequencing

This block turns bytes offered on a valid/ready input into asynchronous serial frames on a single output line. Every frame has a low start bit, 5 to 8 data bits sent least significant bit first, an optional parity bit, one, one and a half or two stop bits, and up to two optional trailing delay bits. After the last frame of a burst it can hold the line low for a counted number of bit times (a break). It then keeps the line high for a counted idle gap before it accepts the next byte. Bit timing comes from an internal divider with an integer part and a fractional part in sixteenths.

The controller is a single enumerated state machine. Its states are IDLE (0), START (1), DATA0 to DATA7 (2 to 9), PARITY (10), STOP1 (11), STOP2 (12), DELAY0 (13), DELAY1 (14) and BREAK (15). The current state is exposed on a status output.

The transitions are as follows, and every one except the acceptance of a byte happens on a bit tick:
- IDLE goes to START when a byte is accepted.
- START goes to DATA0.
- Each DATA state goes to the next DATA state. The last configured data bit goes to PARITY if parity is on, otherwise to STOP1.
- PARITY goes to STOP1.
- STOP1 goes to STOP2 when the stop code is 2 or 3.
- From STOP1 or STOP2 the frame continues to DELAY0, DELAY1 or the frame end, depending on the delay enables.
- DELAY0 goes to DELAY1 or to the frame end.
- At the frame end the machine enters BREAK or IDLE.
- BREAK returns to IDLE after the programmed count.

Inside IDLE an idle-gap counter runs until it has seen the programmed number of bit times. The block pulses `done_pulse` at the frame end, `brk_done_pulse` at the end of a break and `idle_done_pulse` when the gap has elapsed.

Top module: `uart_frame_tx`

## Requirements
- R1: The line idles high. A frame starts with one low bit, followed by `cfg_len`+5 data bits (code 0 to 3 gives 5 to 8 bits), least significant bit first.
- R2: When `cfg_par_en` is 1, one parity bit follows the data. With `cfg_par_odd` 0 the data bits plus parity hold an even number of ones; with `cfg_par_odd` 1 they hold an odd number. When `cfg_par_en` is 0 no parity bit is sent.
- R3: `cfg_stop` 0 or 1 gives one stop bit, 3 gives two full stop bits, and 2 gives one full stop bit plus a half bit. A half bit lasts max(floor(`cfg_div_int`/2),1) cycles. Stop bits are high.
- R4: `state_code` shows the state with the encoding 0 idle, 1 start, 2+k data bit k, 10 parity, 11 stop 1, 12 stop 2, 13 delay 0, 14 delay 1 and 15 break.
- R5: `cfg_dly0` adds one high bit time in state 13 after the stop bits. `cfg_dly1` then adds one high bit time in state 14.
- R6: A full bit lasts max(`cfg_div_int`,1) cycles plus one more cycle when a 4-bit phase accumulator overflows. The accumulator adds `cfg_div_frac` at every full bit of a frame, break or gap. It starts at 0 after reset and is not advanced by half bits.
- R7: The block sends a break when three conditions hold at the moment the last frame bit ends: `cfg_brk_en` is 1, `cfg_brk_len` is nonzero and `in_valid` is low. The line is then held low in state 15 for `cfg_brk_len` full bits, and `brk_done_pulse` is high in the first cycle after the break.
- R8: If `in_valid` is high when the frame ends, no break is sent even with `cfg_brk_en` set.
- R9: After a frame or a break the line stays high in state 0 for `cfg_idle_len` full bits with `in_ready` low. `idle_done_pulse` is high in the first cycle after that. With a count of 0 the pulse comes in the first cycle after the frame or break, and `in_ready` rises in that same cycle.
- R10: `done_pulse` is high for exactly one cycle, the first cycle after the last bit of a frame.
- R11: `cfg_inv` inverts `txd` in every state, idle and break included.
- R12: `in_ready` is high only in IDLE with the gap elapsed. A byte is taken on a clock edge where `in_valid` and `in_ready` are both high, and START shows in the next cycle.
- R13: After reset the state is 0, the line is high (inverted by `cfg_inv`), `in_ready` is high and all pulses are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| in_valid | input | 1 | Byte offered |
| in_data | input | 8 | Byte to send |
| in_ready | output | 1 | Byte can be taken |
| cfg_len | input | 2 | Data-length code, 0..3 for 5..8 bits |
| cfg_par_en | input | 1 | Parity bit enable |
| cfg_par_odd | input | 1 | 0 even parity, 1 odd parity |
| cfg_stop | input | 2 | Stop-length code |
| cfg_dly0 | input | 1 | First trailing delay bit enable |
| cfg_dly1 | input | 1 | Second trailing delay bit enable |
| cfg_brk_en | input | 1 | Break after the last frame enable |
| cfg_brk_len | input | 8 | Break length in bit times |
| cfg_idle_len | input | 10 | Idle gap length in bit times |
| cfg_div_int | input | 20 | Integer part of the bit period in cycles |
| cfg_div_frac | input | 4 | Fractional part of the bit period in sixteenths |
| cfg_inv | input | 1 | Invert the serial output |
| txd | output | 1 | Serial output |
| state_code | output | 4 | Current state encoding |
| done_pulse | output | 1 | Frame finished |
| brk_done_pulse | output | 1 | Break finished |
| idle_done_pulse | output | 1 | Idle gap finished |

## Verification
The bench sweeps every combination of data length, parity and stop code and compares line level and state code cycle by cycle against a waveform it builds from the requirements. A design that miscounted data bits, flipped the parity sense or made the half stop bit a full one would fail on the first frame that differs.

Frames with fractional divisors and a zero integer divisor check that the accumulator carry lands on the right bit. A divider that reset its phase per frame or advanced it on the half bit would drift by a cycle.

Break and idle counts of zero and nonzero, and a frame ending with the next byte already offered, check that the break is skipped and the gap still enforced. A block that tested `in_valid` at the wrong moment would send a break it should not, or take the next byte early.

// File: rtl/uftx_pkg.sv
package uftx_pkg;
    // Exposed state encoding; the numeric values are visible on state_code.
    typedef enum logic [3:0] {
        ST_IDLE  = 4'd0,
        ST_START = 4'd1,
        ST_D0    = 4'd2,
        ST_D1    = 4'd3,
        ST_D2    = 4'd4,
        ST_D3    = 4'd5,
        ST_D4    = 4'd6,
        ST_D5    = 4'd7,
        ST_D6    = 4'd8,
        ST_D7    = 4'd9,
        ST_PAR   = 4'd10,
        ST_STOP1 = 4'd11,
        ST_STOP2 = 4'd12,
        ST_DLY0  = 4'd13,
        ST_DLY1  = 4'd14,
        ST_BRK   = 4'd15
    } tx_state_t;

    localparam int unsigned BYTE_W = 8;
    localparam int unsigned MIN_BITS = 5;
endpackage

// File: rtl/uftx_baud.sv
module uftx_baud #(
    parameter int unsigned DIV_W  = 20,
    parameter int unsigned FRAC_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              run,
    input  logic              half,
    input  logic [DIV_W-1:0]  div_int,
    input  logic [FRAC_W-1:0] div_frac,
    output logic              tick
);
    localparam int unsigned CNT_W = DIV_W + 1;

    logic [CNT_W-1:0]  cnt_q;
    logic [FRAC_W-1:0] acc_q;
    logic [FRAC_W-1:0] acc_sum;
    logic              acc_carry;
    logic [CNT_W-1:0]  base_len;
    logic [CNT_W-1:0]  half_len;
    logic [CNT_W-1:0]  cur_len;

    always_comb begin
        {acc_carry, acc_sum} = {1'b0, acc_q} + {1'b0, div_frac};
        base_len = (div_int == '0) ? CNT_W'(1) : CNT_W'(div_int);
        half_len = (div_int[DIV_W-1:1] == '0) ? CNT_W'(1) : CNT_W'(div_int[DIV_W-1:1]);
        cur_len  = half ? half_len : (base_len + CNT_W'(acc_carry));
    end

    assign tick = run && (cnt_q == cur_len - CNT_W'(1));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            acc_q <= '0;
        end else begin
            if (!run || tick) begin
                cnt_q <= '0;
            end else begin
                cnt_q <= cnt_q + CNT_W'(1);
            end
            if (tick && !half) begin
                acc_q <= acc_sum;
            end
        end
    end

    // R6: the period counter never passes the length of the bit in progress
    p_cnt_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        run |-> (cnt_q < cur_len));
endmodule

// File: rtl/uftx_parity.sv
module uftx_parity #(
    parameter int unsigned DATA_W = 8
) (
    input  logic [DATA_W-1:0] data,
    input  logic [2:0]        last_idx,
    input  logic              odd,
    output logic              par_bit
);
    logic [DATA_W-1:0] used;

    for (genvar k = 0; k < DATA_W; k++) begin : g_mask
        assign used[k] = data[k] && (3'(k) <= last_idx);
    end

    assign par_bit = (^used) ^ odd;
endmodule

// File: rtl/uart_frame_tx.sv
module uart_frame_tx
    import uftx_pkg::*;
#(
    parameter int unsigned DIV_W  = 20,
    parameter int unsigned FRAC_W = 4,
    parameter int unsigned BRK_W  = 8,
    parameter int unsigned IDLE_W = 10
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [7:0]        in_data,
    output logic              in_ready,
    input  logic [1:0]        cfg_len,
    input  logic              cfg_par_en,
    input  logic              cfg_par_odd,
    input  logic [1:0]        cfg_stop,
    input  logic              cfg_dly0,
    input  logic              cfg_dly1,
    input  logic              cfg_brk_en,
    input  logic [BRK_W-1:0]  cfg_brk_len,
    input  logic [IDLE_W-1:0] cfg_idle_len,
    input  logic [DIV_W-1:0]  cfg_div_int,
    input  logic [FRAC_W-1:0] cfg_div_frac,
    input  logic              cfg_inv,
    output logic              txd,
    output logic [3:0]        state_code,
    output logic              done_pulse,
    output logic              brk_done_pulse,
    output logic              idle_done_pulse
);
    tx_state_t         state_q, state_d;
    logic [BYTE_W-1:0] data_q;
    logic [BRK_W-1:0]  brk_cnt_q;
    logic [IDLE_W-1:0] gap_cnt_q;
    logic              gap_done_q;
    logic              line_q, line_d;
    logic              done_q, brk_done_q, idle_done_q;

    logic              tick, run, half, par_bit, accept;
    logic              fin, frame_end, brk_end, gap_end, to_idle, ev_idle;
    logic [2:0]        last_idx, cur_idx, nxt_idx;
    logic [3:0]        cur_raw, nxt_raw;

    assign last_idx = 3'(MIN_BITS - 1) + {1'b0, cfg_len};
    assign cur_raw  = state_q;
    assign nxt_raw  = state_d;
    assign cur_idx  = 3'(cur_raw - 4'd2);
    assign nxt_idx  = 3'(nxt_raw - 4'd2);
    assign in_ready = (state_q == ST_IDLE) && gap_done_q;
    assign accept   = in_valid && in_ready;
    assign run      = (state_q != ST_IDLE) || !gap_done_q;
    assign half     = (state_q == ST_STOP2) && (cfg_stop == 2'd2);

    uftx_baud #(.DIV_W(DIV_W), .FRAC_W(FRAC_W)) u_baud (
        .clk(clk), .rst_n(rst_n), .run(run), .half(half),
        .div_int(cfg_div_int), .div_frac(cfg_div_frac), .tick(tick)
    );

    uftx_parity #(.DATA_W(BYTE_W)) u_par (
        .data(data_q), .last_idx(last_idx), .odd(cfg_par_odd), .par_bit(par_bit)
    );

    // Next-state logic
    always_comb begin
        state_d = state_q;
        fin     = 1'b0;
        brk_end = 1'b0;
        unique case (state_q)
            ST_IDLE:  if (accept) state_d = ST_START;
            ST_START: if (tick) state_d = ST_D0;
            ST_D0, ST_D1, ST_D2, ST_D3, ST_D4, ST_D5, ST_D6, ST_D7: begin
                if (tick) begin
                    if (cur_idx == last_idx) state_d = cfg_par_en ? ST_PAR : ST_STOP1;
                    else                     state_d = tx_state_t'(cur_raw + 4'd1);
                end
            end
            ST_PAR:   if (tick) state_d = ST_STOP1;
            ST_STOP1, ST_STOP2: begin
                if (tick) begin
                    if (state_q == ST_STOP1 && cfg_stop[1]) state_d = ST_STOP2;
                    else if (cfg_dly0)                      state_d = ST_DLY0;
                    else if (cfg_dly1)                      state_d = ST_DLY1;
                    else                                    fin = 1'b1;
                end
            end
            ST_DLY0: begin
                if (tick) begin
                    if (cfg_dly1) state_d = ST_DLY1;
                    else          fin = 1'b1;
                end
            end
            ST_DLY1:  if (tick) fin = 1'b1;
            ST_BRK: begin
                if (tick && brk_cnt_q == cfg_brk_len - BRK_W'(1)) begin
                    state_d = ST_IDLE;
                    brk_end = 1'b1;
                end
            end
        endcase
        frame_end = fin;
        if (fin) begin
            state_d = (cfg_brk_en && cfg_brk_len != '0 && !in_valid) ? ST_BRK : ST_IDLE;
        end
        to_idle = (frame_end && state_d == ST_IDLE) || brk_end;
        gap_end = (state_q == ST_IDLE) && !gap_done_q && tick &&
                  (gap_cnt_q == cfg_idle_len - IDLE_W'(1));
        ev_idle = gap_end || (to_idle && cfg_idle_len == '0);
    end

    // Line level of the state being entered
    always_comb begin
        unique case (state_d)
            ST_START, ST_BRK: line_d = 1'b0;
            ST_D0, ST_D1, ST_D2, ST_D3, ST_D4, ST_D5, ST_D6, ST_D7: line_d = data_q[nxt_idx];
            ST_PAR:           line_d = par_bit;
            default:          line_d = 1'b1;
        endcase
    end

    // State register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    // Data, break and idle-gap counters
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q     <= '0;
            brk_cnt_q  <= '0;
            gap_cnt_q  <= '0;
            gap_done_q <= 1'b1;
        end else begin
            if (accept) data_q <= in_data;
            if (frame_end)                        brk_cnt_q <= '0;
            else if (state_q == ST_BRK && tick)   brk_cnt_q <= brk_cnt_q + BRK_W'(1);
            if (to_idle) begin
                gap_done_q <= (cfg_idle_len == '0);
                gap_cnt_q  <= '0;
            end else if (gap_end) begin
                gap_done_q <= 1'b1;
            end else if (state_q == ST_IDLE && !gap_done_q && tick) begin
                gap_cnt_q  <= gap_cnt_q + IDLE_W'(1);
            end
        end
    end

    // Outputs
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            line_q      <= 1'b1;
            done_q      <= 1'b0;
            brk_done_q  <= 1'b0;
            idle_done_q <= 1'b0;
        end else begin
            line_q      <= line_d;
            done_q      <= frame_end;
            brk_done_q  <= brk_end;
            idle_done_q <= ev_idle;
        end
    end

    assign txd             = line_q ^ cfg_inv;
    assign state_code      = state_q;
    assign done_pulse      = done_q;
    assign brk_done_pulse  = brk_done_q;
    assign idle_done_pulse = idle_done_q;

    // R12: an accepted byte always opens a frame with the start state
    p_accept_start_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_ready) |=> (state_q == ST_START));
    // R10: frame-done is a single-cycle pulse
    p_done_single_r10: assert property (@(posedge clk) disable iff (!rst_n)
        done_q |=> !done_q);
    // R7: frame-done and break-done never coincide
    p_pulse_excl_r7: assert property (@(posedge clk) disable iff (!rst_n)
        !(done_q && brk_done_q));
    // R7: the line is low throughout a break
    p_break_low_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_BRK) |-> !line_q);
    // R3: stop and delay bits are high
    p_stop_high_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_STOP1 || state_q == ST_STOP2 ||
         state_q == ST_DLY0 || state_q == ST_DLY1) |-> line_q);
    // R9: the idle-done pulse is only seen in the idle state
    p_idle_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        idle_done_q |-> (state_q == ST_IDLE));
    // R6: a busy state only changes on a bit tick
    p_move_on_tick_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q != ST_IDLE && !tick) |=> $stable(state_q));
endmodule

// File: tb/uart_frame_tx_bench.sv
`timescale 1ns/1ps
module uart_frame_tx_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0;
    logic [7:0]  in_data = '0;
    logic        in_ready;
    logic [1:0]  cfg_len = 2'd3;
    logic        cfg_par_en = 1'b0;
    logic        cfg_par_odd = 1'b0;
    logic [1:0]  cfg_stop = 2'd1;
    logic        cfg_dly0 = 1'b0;
    logic        cfg_dly1 = 1'b0;
    logic        cfg_brk_en = 1'b0;
    logic [7:0]  cfg_brk_len = '0;
    logic [9:0]  cfg_idle_len = '0;
    logic [19:0] cfg_div_int = 20'd3;
    logic [3:0]  cfg_div_frac = '0;
    logic        cfg_inv = 1'b0;
    logic        txd;
    logic [3:0]  state_code;
    logic        done_pulse, brk_done_pulse, idle_done_pulse;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int acc_m = 0;

    int e_state [0:2047];
    bit e_txd   [0:2047];
    bit e_rdy   [0:2047];
    bit e_done  [0:2047];
    bit e_brk   [0:2047];
    bit e_idle  [0:2047];
    int n_exp;

    always #2 clk = ~clk;

    uart_frame_tx u_uart_frame_tx (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_data(in_data),
        .in_ready(in_ready), .cfg_len(cfg_len), .cfg_par_en(cfg_par_en),
        .cfg_par_odd(cfg_par_odd), .cfg_stop(cfg_stop), .cfg_dly0(cfg_dly0),
        .cfg_dly1(cfg_dly1), .cfg_brk_en(cfg_brk_en), .cfg_brk_len(cfg_brk_len),
        .cfg_idle_len(cfg_idle_len), .cfg_div_int(cfg_div_int),
        .cfg_div_frac(cfg_div_frac), .cfg_inv(cfg_inv), .txd(txd),
        .state_code(state_code), .done_pulse(done_pulse),
        .brk_done_pulse(brk_done_pulse), .idle_done_pulse(idle_done_pulse)
    );

    task automatic report;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            checks = checks + 1;
            fails = fails + 1;
            $display("FAIL watchdog: run hung, actual %0d cycles expected < 150000", cyc);
            report();
        end
    end

    task automatic check(input bit ok, input string tag, input int act, input int expv);
        checks = checks + 1;
        if (!ok) begin
            fails = fails + 1;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    // R6 model: full bit length with the phase accumulator
    function automatic int full_len();
        int b = (cfg_div_int == 0) ? 1 : int'(cfg_div_int);
        int s = acc_m + int'(cfg_div_frac);
        acc_m = s % 16;
        return b + ((s >= 16) ? 1 : 0);
    endfunction

    function automatic int half_len();
        int h = int'(cfg_div_int) / 2;
        return (h == 0) ? 1 : h;
    endfunction

    task automatic seg(input int code, input bit lvl, input int len, input bit rdy);
        for (int i = 0; i < len; i++) begin
            e_state[n_exp] = code;
            e_txd[n_exp]   = lvl ^ cfg_inv;
            e_rdy[n_exp]   = rdy;
            e_done[n_exp]  = 1'b0;
            e_brk[n_exp]   = 1'b0;
            e_idle[n_exp]  = 1'b0;
            n_exp++;
        end
    endtask

    task automatic build(input logic [7:0] d);
        int nb = int'(cfg_len) + 5;
        int ones = 0;
        int i_done, i_brk, i_idle;
        bit par;
        n_exp = 0;
        seg(1, 1'b0, full_len(), 1'b0);
        for (int k = 0; k < nb; k++) begin
            seg(2 + k, d[k], full_len(), 1'b0);
            ones += int'(d[k]);
        end
        par = ((ones % 2) == 1) ^ cfg_par_odd;
        if (cfg_par_en) seg(10, par, full_len(), 1'b0);
        seg(11, 1'b1, full_len(), 1'b0);
        if (cfg_stop == 2'd3)      seg(12, 1'b1, full_len(), 1'b0);
        else if (cfg_stop == 2'd2) seg(12, 1'b1, half_len(), 1'b0);
        if (cfg_dly0) seg(13, 1'b1, full_len(), 1'b0);
        if (cfg_dly1) seg(14, 1'b1, full_len(), 1'b0);
        i_done = n_exp;
        i_brk = -1;
        if (cfg_brk_en && cfg_brk_len != 0) begin
            for (int b = 0; b < int'(cfg_brk_len); b++) seg(15, 1'b0, full_len(), 1'b0);
            i_brk = n_exp;
        end
        for (int g = 0; g < int'(cfg_idle_len); g++) seg(0, 1'b1, full_len(), 1'b0);
        i_idle = n_exp;
        seg(0, 1'b1, 4, 1'b1);
        e_done[i_done] = 1'b1;
        if (i_brk >= 0) e_brk[i_brk] = 1'b1;
        e_idle[i_idle] = 1'b1;
    endtask

    // Send one byte with in_valid dropped after acceptance; compare every cycle.
    task automatic run_frame(input logic [7:0] d, input string tag);
        bit ok = 1'b1;
        int bad_i = -1;
        int act = 0, expv = 0;
        build(d);
        @(negedge clk);
        in_valid = 1'b1;
        in_data  = d;
        while (!in_ready) @(negedge clk);
        @(posedge clk);
        @(negedge clk);
        in_valid = 1'b0;
        for (int i = 0; i < n_exp; i++) begin
            if (ok && (int'(state_code) != e_state[i] || txd != e_txd[i] ||
                       in_ready != e_rdy[i] || done_pulse != e_done[i] ||
                       brk_done_pulse != e_brk[i] || idle_done_pulse != e_idle[i])) begin
                ok = 1'b0;
                bad_i = i;
                act  = {state_code, txd, in_ready, done_pulse, brk_done_pulse, idle_done_pulse};
                expv = {e_state[i][3:0], e_txd[i], e_rdy[i], e_done[i], e_brk[i], e_idle[i]};
            end
            if (i < n_exp - 1) @(negedge clk);
        end
        if (!ok) $display("     (%s) first mismatch at cycle %0d of frame data %02h", tag, bad_i, d);
        check(ok, tag, act, expv);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R13: reset state
        check(state_code == 4'd0, "R13 state", int'(state_code), 0);
        check(txd == 1'b1, "R13 txd", int'(txd), 1);
        check(in_ready == 1'b1, "R13 ready", int'(in_ready), 1);
        check({done_pulse, brk_done_pulse, idle_done_pulse} == 3'b000, "R13 pulses",
              int'({done_pulse, brk_done_pulse, idle_done_pulse}), 0);
        rst_n = 1'b1;
        @(negedge clk);

        // R1 R2 R3 R4: sweep data length, parity mode and stop code
        cfg_div_int = 20'd3;
        for (int ln = 0; ln < 4; ln++) begin
            for (int pm = 0; pm < 3; pm++) begin
                for (int st = 0; st < 4; st++) begin
                    cfg_len = 2'(ln);
                    cfg_par_en = (pm != 0);
                    cfg_par_odd = (pm == 2);
                    cfg_stop = 2'(st);
                    run_frame(8'(8'h5A ^ (ln * 37 + pm * 11 + st * 71)), "R1 R2 R3 R4 frame sweep");
                end
            end
        end

        // R5: trailing delay bits
        cfg_len = 2'd3; cfg_par_en = 1'b1; cfg_par_odd = 1'b0;
        for (int dm = 0; dm < 4; dm++) begin
            cfg_dly0 = dm[0];
            cfg_dly1 = dm[1];
            cfg_stop = dm[0] ? 2'd3 : 2'd2;
            run_frame(8'(8'hC3 + dm), "R5 delay bits");
        end
        cfg_dly0 = 1'b0; cfg_dly1 = 1'b0; cfg_stop = 2'd1;

        // R6: fractional divider, including a zero integer part
        cfg_div_int = 20'd2;
        cfg_par_en = 1'b0;
        for (int f = 0; f < 3; f++) begin
            cfg_div_frac = (f == 0) ? 4'd1 : ((f == 1) ? 4'd5 : 4'd15);
            cfg_stop = 2'(f + 1);
            run_frame(8'(8'h96 + f), "R6 fractional period");
            run_frame(8'(8'h0F + f), "R6 fractional period");
        end
        cfg_div_int = 20'd0; cfg_div_frac = 4'd8; cfg_stop = 2'd2;
        run_frame(8'hA5, "R6 zero integer divisor");
        cfg_div_int = 20'd4; cfg_div_frac = 4'd3;
        run_frame(8'h3C, "R6 fractional period");

        // R7 R9 R10: break and idle counts
        cfg_div_frac = 4'd0; cfg_div_int = 20'd3; cfg_stop = 2'd1;
        cfg_brk_en = 1'b1;
        for (int bm = 0; bm < 4; bm++) begin
            cfg_brk_len  = bm[0] ? 8'd3 : 8'd1;
            cfg_idle_len = bm[1] ? 10'd2 : 10'd0;
            run_frame(8'(8'h21 + bm * 3), "R7 R9 R10 break then idle");
        end
        // R9: break enabled but length 0 means idle gap only
        cfg_brk_len = 8'd0; cfg_idle_len = 10'd4;
        run_frame(8'h7E, "R9 idle gap without break");
        cfg_brk_en = 1'b0; cfg_idle_len = 10'd1;
        run_frame(8'h81, "R9 R10 idle gap");

        // R11: inverted output through frame, break and idle
        cfg_inv = 1'b1; cfg_brk_en = 1'b1; cfg_brk_len = 8'd2; cfg_par_en = 1'b1;
        cfg_par_odd = 1'b1;
        run_frame(8'h6B, "R11 inverted line");
        cfg_inv = 1'b0; cfg_par_en = 1'b0;

        // R8 R12: next byte offered at frame end suppresses the break; gap still enforced
        begin
            int gap_cycles = 0;
            bit saw_brk = 1'b0;
            int guard = 0;
            cfg_brk_len = 8'd3; cfg_idle_len = 10'd2;
            @(negedge clk);
            in_valid = 1'b1; in_data = 8'h11;
            while (!in_ready) @(negedge clk);
            @(posedge clk);
            @(negedge clk);
            in_data = 8'h22;
            while (!done_pulse && guard < 1000) begin @(negedge clk); guard++; end
            while (state_code != 4'd1 && guard < 1000) begin
                if (state_code == 4'd15) saw_brk = 1'b1;
                gap_cycles++; guard++;
                @(negedge clk);
            end
            in_valid = 1'b0;
            check(!saw_brk, "R8 break suppressed", int'(saw_brk), 0);
            check(gap_cycles == 2 * 3 + 1, "R12 R9 gap before next start", gap_cycles, 7);
            guard = 0;
            while (!idle_done_pulse && guard < 1000) begin @(negedge clk); guard++; end
            check(in_ready == 1'b1, "R12 ready after gap", int'(in_ready), 1);
        end

        report();
    end
endmodule